// File: doc/BRIEF.md
# Ready/Valid Stream Rule Monitor

This block is a passive observer for one ready/valid link where a producer and a consumer share one clock. It samples the payload, valid and ready lines on every edge and never drives them. It keeps a record of the previous cycle and checks the handshake contract against it. Once valid is raised while the consumer stalls, valid must stay up and the payload must stay frozen until a transfer completes. On a link built with ready or valid tied high, the tied line must never read 0. The monitor also counts completed transfers.

Each rule has its own error flag, and every flag stays set until reset. A combined error flag summarises the four errors. A separate sticky warning marks a suspected ready-to-valid dependency: valid rises in a cycle where ready is high, and ready was already high while valid was low on the cycle before. Rule checking is suppressed during reset and on the first edge after reset, because there is no previous cycle to compare against then.

Top module: `stream_rule_monitor`

## Requirements
- R1: `xfer_cnt_o` increments by exactly one on each clock edge that samples `vld_i` and `rdy_i` both at 1. It holds on every other edge and wraps modulo 2^CNT_W. CNT_W defaults to 32.
- R2: If an evaluated edge samples `vld_i`=1 and `rdy_i`=0 and the next edge samples `vld_i`=0, `err_withdraw_o` is 1 from that next edge on.
- R3: If an evaluated edge samples `vld_i`=1 and `rdy_i`=0 and the next edge samples `vld_i`=1 with a different `data_i`, `err_unstable_o` is 1 from that next edge on. This holds even when that next edge completes a transfer.
- R4: The flags stay 0 under legal traffic. That traffic includes stalls, back-to-back transfers, a new payload after a transfer, and `rdy_i` toggling while `vld_i` is low or before any stall.
- R5: With ALWAYS_RDY=1, any evaluated edge that samples `rdy_i`=0 sets `err_rdy_tie_o`. With ALWAYS_RDY=0 this flag never sets.
- R6: With ALWAYS_VLD=1, any evaluated edge that samples `vld_i`=0 sets `err_vld_tie_o`. With ALWAYS_VLD=0 this flag never sets.
- R7: An evaluated edge that samples `vld_i`=1 and `rdy_i`=1, where the previous edge sampled `vld_i`=0 and `rdy_i`=1, sets `warn_dep_o`. The warning does not affect `err_any_o`.
- R8: Every flag stays set until reset. `err_any_o` is 1 exactly when at least one of the four error flags is 1. The flag vector used in checks is {withdraw, unstable, rdy_tie, vld_tie, any, warn}, with withdraw as the most significant bit.
- R9: While `rst_ni` is 0, all flags and the counter read 0. The first edge after reset evaluates no rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the link and the monitor |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| data_i | input | DATA_W | Observed payload |
| vld_i | input | 1 | Observed valid |
| rdy_i | input | 1 | Observed ready |
| err_withdraw_o | output | 1 | Sticky: valid dropped during a stall |
| err_unstable_o | output | 1 | Sticky: payload changed during a stall |
| err_rdy_tie_o | output | 1 | Sticky: tied-high ready read 0 |
| err_vld_tie_o | output | 1 | Sticky: tied-high valid read 0 |
| err_any_o | output | 1 | OR of the four error flags |
| warn_dep_o | output | 1 | Sticky: suspected ready-to-valid dependency |
| xfer_cnt_o | output | CNT_W | Count of completed transfers |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a payload change at the end of a stall that also completes a transfer. The bench drives a stalled word and then presents a different word with ready high. It expects `err_unstable_o` to set and the counter to advance by one on that edge. The second pair is the dependency warning and a transfer: valid rises into an already-high ready. The bench expects `warn_dep_o` to set, `err_any_o` to stay 0, and the counter to advance.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int unsigned NUM_ERR = 4;

  // bit positions inside the error vector
  localparam int unsigned IDX_WITHDRAW = 0;
  localparam int unsigned IDX_UNSTABLE = 1;
  localparam int unsigned IDX_RDY_TIE  = 2;
  localparam int unsigned IDX_VLD_TIE  = 3;

  typedef struct packed {
    logic               dep_warn;
    logic [NUM_ERR-1:0] err;
  } hits_t;

  localparam int unsigned HITS_W = $bits(hits_t);
endpackage

// File: rtl/smon_history.sv
module smon_history #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vld_i,
  input  logic              rdy_i,
  output logic              armed_o,
  output logic              vld_q_o,
  output logic              rdy_q_o,
  output logic [DATA_W-1:0] data_q_o
);
  logic              armed_d, armed_q;
  logic              vld_d, vld_q;
  logic              rdy_d, rdy_q;
  logic              data_en;
  logic [DATA_W-1:0] data_d, data_q;

  // next state: armed goes high after the first edge out of reset
  always_comb begin
    armed_d = 1'b1;
    vld_d   = vld_i;
    rdy_d   = rdy_i;
    data_en = vld_i;
    data_d  = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      vld_q   <= vld_d;
      rdy_q   <= rdy_d;
    end
  end

  // payload is only compared when valid was high, so capture only then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign armed_o  = armed_q;
  assign vld_q_o  = vld_q;
  assign rdy_q_o  = rdy_q;
  assign data_q_o = data_q;
endmodule

// File: rtl/smon_rules.sv
module smon_rules
  import smon_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          ALWAYS_RDY = 1'b0,
  parameter bit          ALWAYS_VLD = 1'b0
) (
  input  logic              armed_i,
  input  logic              vld_q_i,
  input  logic              rdy_q_i,
  input  logic [DATA_W-1:0] data_q_i,
  input  logic              vld_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] data_i,
  output hits_t             hits_o
);
  logic stalled;
  logic rdy_tie_hit;
  logic vld_tie_hit;

  // previous cycle offered data that the consumer did not take
  assign stalled = armed_i & vld_q_i & ~rdy_q_i;

  generate
    if (ALWAYS_RDY) begin : g_rdy_tied
      assign rdy_tie_hit = armed_i & ~rdy_i;
    end else begin : g_rdy_free
      assign rdy_tie_hit = 1'b0;
    end
    if (ALWAYS_VLD) begin : g_vld_tied
      assign vld_tie_hit = armed_i & ~vld_i;
    end else begin : g_vld_free
      assign vld_tie_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    hits_o                    = '0;
    hits_o.err[IDX_WITHDRAW]  = stalled & ~vld_i;
    hits_o.err[IDX_UNSTABLE]  = stalled & vld_i & (data_i != data_q_i);
    hits_o.err[IDX_RDY_TIE]   = rdy_tie_hit;
    hits_o.err[IDX_VLD_TIE]   = vld_tie_hit;
    hits_o.dep_warn           = armed_i & ~vld_q_i & rdy_q_i & vld_i & rdy_i;
  end
endmodule

// File: rtl/smon_sticky.sv
module smon_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_flag
      logic flag_d, flag_q, flag_en;

      always_comb begin
        flag_en = set_i[g] & ~flag_q;
        flag_d  = 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flag_q <= 1'b0;
        end else if (flag_en) begin
          flag_q <= flag_d;
        end
      end

      assign flag_o[g] = flag_q;
    end
  endgenerate
endmodule

// File: rtl/smon_xfer_count.sv
module smon_xfer_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i;
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stream_rule_monitor.sv
module stream_rule_monitor
  import smon_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          ALWAYS_RDY = 1'b0,
  parameter bit          ALWAYS_VLD = 1'b0,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vld_i,
  input  logic              rdy_i,
  output logic              err_withdraw_o,
  output logic              err_unstable_o,
  output logic              err_rdy_tie_o,
  output logic              err_vld_tie_o,
  output logic              err_any_o,
  output logic              warn_dep_o,
  output logic [CNT_W-1:0]  xfer_cnt_o
);
  logic              armed;
  logic              vld_q;
  logic              rdy_q;
  logic [DATA_W-1:0] data_q;
  hits_t             hits;
  hits_t             flags;

  smon_history #(.DATA_W(DATA_W)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .vld_i    (vld_i),
    .rdy_i    (rdy_i),
    .armed_o  (armed),
    .vld_q_o  (vld_q),
    .rdy_q_o  (rdy_q),
    .data_q_o (data_q)
  );

  smon_rules #(
    .DATA_W     (DATA_W),
    .ALWAYS_RDY (ALWAYS_RDY),
    .ALWAYS_VLD (ALWAYS_VLD)
  ) u_rules (
    .armed_i  (armed),
    .vld_q_i  (vld_q),
    .rdy_q_i  (rdy_q),
    .data_q_i (data_q),
    .vld_i    (vld_i),
    .rdy_i    (rdy_i),
    .data_i   (data_i),
    .hits_o   (hits)
  );

  smon_sticky #(.N(HITS_W)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hits),
    .flag_o (flags)
  );

  smon_xfer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (vld_i & rdy_i),
    .cnt_o  (xfer_cnt_o)
  );

  assign err_withdraw_o = flags.err[IDX_WITHDRAW];
  assign err_unstable_o = flags.err[IDX_UNSTABLE];
  assign err_rdy_tie_o  = flags.err[IDX_RDY_TIE];
  assign err_vld_tie_o  = flags.err[IDX_VLD_TIE];
  assign err_any_o      = |flags.err;
  assign warn_dep_o     = flags.dep_warn;
endmodule

// File: rtl/smon_props.sv
module smon_props #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          ALWAYS_RDY = 1'b0,
  parameter bit          ALWAYS_VLD = 1'b0,
  parameter int unsigned CNT_W      = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              vld_i,
  input logic              rdy_i,
  input logic              err_withdraw_o,
  input logic              err_unstable_o,
  input logic              err_rdy_tie_o,
  input logic              err_vld_tie_o,
  input logic              err_any_o,
  input logic              warn_dep_o,
  input logic [CNT_W-1:0]  xfer_cnt_o
);
  // set once the first edge after reset has passed
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && rdy_i) |=> (xfer_cnt_o == $past(xfer_cnt_o) + 1'b1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_i && rdy_i) |=> $stable(xfer_cnt_o));

  // R2
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(vld_i) && !$past(rdy_i) && !vld_i) |=> err_withdraw_o);

  // R3
  unstable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(vld_i) && !$past(rdy_i) && vld_i && (data_i != $past(data_i)))
    |=> err_unstable_o);

  // R5
  rdy_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ALWAYS_RDY && seen_q && !rdy_i) |=> err_rdy_tie_o);

  // R6
  vld_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ALWAYS_VLD && seen_q && !vld_i) |=> err_vld_tie_o);

  // R7
  dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(vld_i) && $past(rdy_i) && vld_i && rdy_i) |=> warn_dep_o);

  // R7
  warn_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_dep_o && !err_withdraw_o && !err_unstable_o && !err_rdy_tie_o && !err_vld_tie_o)
    |-> !err_any_o);

  // R8
  any_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any_o |=> err_any_o);

  // R8
  warn_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_dep_o |=> warn_dep_o);

  // R9
  first_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |=> (!err_any_o && !warn_dep_o));
endmodule

bind stream_rule_monitor smon_props #(
  .DATA_W     (DATA_W),
  .ALWAYS_RDY (ALWAYS_RDY),
  .ALWAYS_VLD (ALWAYS_VLD),
  .CNT_W      (CNT_W)
) u_props (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .data_i         (data_i),
  .vld_i          (vld_i),
  .rdy_i          (rdy_i),
  .err_withdraw_o (err_withdraw_o),
  .err_unstable_o (err_unstable_o),
  .err_rdy_tie_o  (err_rdy_tie_o),
  .err_vld_tie_o  (err_vld_tie_o),
  .err_any_o      (err_any_o),
  .warn_dep_o     (warn_dep_o),
  .xfer_cnt_o     (xfer_cnt_o)
);

// File: tb/sim_stream_rule_monitor.sv
module sim_stream_rule_monitor;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       a_vld, a_rdy, b_vld, b_rdy;
  logic [7:0] a_data, b_data;

  logic        a_wd, a_us, a_rt, a_vt, a_any, a_warn;
  logic [31:0] a_cnt;
  logic        b_wd, b_us, b_rt, b_vt, b_any, b_warn;
  logic [2:0]  b_cnt;

  wire [5:0] a_flags = {a_wd, a_us, a_rt, a_vt, a_any, a_warn};
  wire [5:0] b_flags = {b_wd, b_us, b_rt, b_vt, b_any, b_warn};

  // flag vector order: {withdraw, unstable, rdy_tie, vld_tie, any, warn}
  localparam logic [5:0] F_NONE = 6'b000000;
  localparam logic [5:0] F_WD   = 6'b100010;
  localparam logic [5:0] F_US   = 6'b010010;
  localparam logic [5:0] F_RT   = 6'b001010;
  localparam logic [5:0] F_VT   = 6'b000110;
  localparam logic [5:0] F_WARN = 6'b000001;

  stream_rule_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(a_data), .vld_i(a_vld), .rdy_i(a_rdy),
    .err_withdraw_o(a_wd), .err_unstable_o(a_us), .err_rdy_tie_o(a_rt),
    .err_vld_tie_o(a_vt), .err_any_o(a_any), .warn_dep_o(a_warn), .xfer_cnt_o(a_cnt)
  );

  stream_rule_monitor #(.ALWAYS_RDY(1'b1), .ALWAYS_VLD(1'b1), .CNT_W(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(b_data), .vld_i(b_vld), .rdy_i(b_rdy),
    .err_withdraw_o(b_wd), .err_unstable_o(b_us), .err_rdy_tie_o(b_rt),
    .err_vld_tie_o(b_vt), .err_any_o(b_any), .warn_dep_o(b_warn), .xfer_cnt_o(b_cnt)
  );

  typedef struct packed {
    logic       v;
    logic       r;
    logic [7:0] d;
    logic [7:0] c;
  } vec_t;

  // legal traffic for u0; c is the expected transfer count after the edge
  localparam vec_t VEC [14] = '{
    '{1'b0, 1'b0, 8'h00, 8'd0},
    '{1'b1, 1'b0, 8'hA5, 8'd0},
    '{1'b1, 1'b0, 8'hA5, 8'd0},
    '{1'b1, 1'b1, 8'hA5, 8'd1},
    '{1'b1, 1'b1, 8'h3C, 8'd2},
    '{1'b1, 1'b0, 8'h44, 8'd2},
    '{1'b1, 1'b1, 8'h44, 8'd3},
    '{1'b0, 1'b1, 8'h00, 8'd3},
    '{1'b0, 1'b0, 8'hFF, 8'd3},
    '{1'b0, 1'b1, 8'h11, 8'd3},
    '{1'b0, 1'b0, 8'h22, 8'd3},
    '{1'b1, 1'b0, 8'h77, 8'd3},
    '{1'b1, 1'b1, 8'h77, 8'd4},
    '{1'b0, 1'b0, 8'h00, 8'd4}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change at a falling edge; outputs are read at the next falling edge
  task automatic step(input logic v, input logic r, input logic [7:0] d,
                      input logic bv, input logic br);
    a_vld = v; a_rdy = r; a_data = d;
    b_vld = bv; b_rdy = br;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_vld = 1'b0; a_rdy = 1'b0; a_data = 8'h00;
    b_vld = 1'b1; b_rdy = 1'b1; b_data = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_vld = 1'b0; a_rdy = 1'b0; a_data = 8'h00;
    b_vld = 1'b1; b_rdy = 1'b1; b_data = 8'h00;
    repeat (3) @(negedge clk);

    // R9: reset state
    chk("R9 reset flags u0", {26'd0, a_flags}, 32'd0);
    chk("R9 reset count u0", a_cnt, 32'd0);
    chk("R9 reset flags u1", {26'd0, b_flags}, 32'd0);
    rst_n = 1'b1;

    // R4 and R1: legal traffic table
    for (int i = 0; i < 14; i++) begin
      step(VEC[i].v, VEC[i].r, VEC[i].d, 1'b1, 1'b1);
      chk($sformatf("R4 vec%0d flags", i), {26'd0, a_flags}, {26'd0, F_NONE});
      chk($sformatf("R1 vec%0d count", i), a_cnt, {24'd0, VEC[i].c});
    end

    // R2 then R8: withdraw stays set across later legal traffic
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b1, 1'b0, 8'h05, 1'b1, 1'b1);
    step(1'b0, 1'b0, 8'h05, 1'b1, 1'b1);
    chk("R2 withdraw only", {26'd0, a_flags}, {26'd0, F_WD});
    step(1'b1, 1'b1, 8'h09, 1'b1, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R8 withdraw sticky", {26'd0, a_flags}, {26'd0, F_WD});
    chk("R1 count after withdraw", a_cnt, 32'd1);

    // R3: payload change on the edge that also transfers
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b1, 1'b0, 8'h05, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'h06, 1'b1, 1'b1);
    chk("R3 unstable only", {26'd0, a_flags}, {26'd0, F_US});
    chk("R1 count with unstable", a_cnt, 32'd1);

    // R7: valid rises into a ready that was already high
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'h03, 1'b1, 1'b1);
    chk("R7 warn only, any clear", {26'd0, a_flags}, {26'd0, F_WARN});
    chk("R1 count with warn", a_cnt, 32'd1);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R8 warn sticky", {26'd0, a_flags}, {26'd0, F_WARN});

    // R9: tie violations on the first edge after reset are not evaluated; R1 wrap
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R9 first edge exempt u1", {26'd0, b_flags}, {26'd0, F_NONE});
    for (int k = 0; k < 10; k++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk("R1 wrap count u1", {29'd0, b_cnt}, 32'd2);
    chk("R5 R6 tied lines high no flag", {26'd0, b_flags}, {26'd0, F_NONE});
    chk("R5 free ready on u0 no tie flag", {31'd0, a_rt}, 32'd0);

    // R5: tied ready drops
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    chk("R5 rdy tie only", {26'd0, b_flags}, {26'd0, F_RT});
    chk("R1 no count on stall u1", {29'd0, b_cnt}, 32'd2);

    // R6: tied valid drops after a transfer
    do_reset();
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    chk("R6 vld tie only", {26'd0, b_flags}, {26'd0, F_VT});
    chk("R6 free valid on u0 no tie flag", {31'd0, a_vt}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule